// File: doc/BRIEF.md
# Register Write Sequencer

This block runs a list of register updates by itself, so a host needs only one command to start a whole series of writes. It holds a bank of target registers, a small step memory and a control register. Each step in the step memory names a target register and carries a data value, a field width and a bit position. The sequencer reads the target register, replaces only the chosen bit-field and writes the result back. The host does not have to read, modify and write the register itself.

The host starts a sequence by writing a start bit and a starting step index to the control register. The sequencer then executes one step per clock. A step can ask for a pause, counted in pulses of an external timebase strobe, before the next step runs. A step flagged as the last one returns the block to idle and raises a done flag. While the sequence runs, the host is locked out of the block except for the abort bit. Writing the abort bit stops the sequence at once and gives register access back to the host.

Top module: `reg_write_sequencer`

## Requirements
- R1: After reset, busy and done are 0 and every target register reads 0.
- R2: While idle, a host write to an address below NREG stores the host data in that target register. host_raddr selects a register for the combinational read port. The control register sits at address 8'hFF and reads as {zeros, done (bit 1), busy (bit 0)}.
- R3: While idle, a host write to address 8'hFF with bit 0 = 1 and bit 1 = 0 sets busy on the next clock edge, clears done and loads the step pointer from bits [11:8] of the write. The first step runs on the following edge, and after that one step runs per clock when no step asks for a pause.
- R4: A step rewrites its target as new = (old & ~mask) | ((data << pos) & mask), where mask = ~(all-ones << width) << pos. Bits pushed past bit 15 are dropped. A width of 16 or more covers the whole word, and a width of 0 leaves the register unchanged.
- R5: When a step whose last flag is set completes, busy falls and done rises on the same edge, and no further step runs. busy and done are never high together, and a new start clears done.
- R6: A step with a delay field d > 0 keeps the sequencer waiting until d pulses of tick have been seen. The next step (or the finish) then follows. With no tick pulses, the sequencer waits indefinitely.
- R7: While busy, host writes to target registers and further start commands are ignored.
- R8: While busy, a host write to 8'hFF with bit 1 = 1 clears busy on the next edge. done stays 0, and no further step is written. Host writes to target registers then work again.
- R9: After a step without the last flag, the step pointer advances by one and wraps from the last index (15) back to 0.
- R10: A write on the step port (ram_we) stores ram_wdata at ram_addr while idle and is ignored while busy. The step word layout is: target address [7:0], data [23:8], width [28:24], position [32:29], delay [36:33], last flag [37].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host write address |
| host_wdata | input | DW (16) | Host write data |
| host_raddr | input | 8 | Host read address |
| host_rdata | output | DW (16) | Host read data (combinational) |
| ram_we | input | 1 | Step memory write strobe |
| ram_addr | input | RAM_AW (4) | Step memory write index |
| ram_wdata | input | 38 | Step word |
| tick | input | 1 | Timebase strobe for step delays |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last sequence finished normally |

## Verification
The assertions check the following on every cycle:
- a start from idle always raises busy;
- an abort always drops busy without raising done;
- busy and done never overlap;
- the step pointer holds while waiting without a tick, and advances by one (with wrap) after each step that does not wait or end.

Only the bench scenarios show the field merge results for various widths and positions, and the exact cycle in which each step lands. They also show that locked-out host writes and step-memory writes while busy leave no trace, and that an abort prevents the pending step.

// File: rtl/reg_write_sequencer.sv
module reg_write_sequencer #(
  parameter int DW = 16,
  parameter int NREG = 16,
  parameter int RAM_AW = 4,
  parameter logic [7:0] CTRL_ADDR = 8'hFF,
  localparam int WW = $clog2(DW) + 1,
  localparam int PW = $clog2(DW),
  localparam int STEP_W = 8 + DW + WW + PW + 4 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [7:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic [7:0]        host_raddr,
  output logic [DW-1:0]     host_rdata,
  input  logic              ram_we,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic [STEP_W-1:0] ram_wdata,
  input  logic              tick,
  output logic              busy,
  output logic              done
);
  localparam int NSTEP = 1 << RAM_AW;
  localparam int RIW = $clog2(NREG);
  localparam int DL = 8;
  localparam int WL = DL + DW;
  localparam int PL = WL + WW;
  localparam int YL = PL + PW;
  localparam int EL = YL + 4;
  localparam logic [7:0] NREG_L = 8'(NREG);

  logic [DW-1:0]     regs [NREG];
  logic [STEP_W-1:0] ram  [NSTEP];
  logic [RAM_AW-1:0] ptr;
  logic              in_wait;
  logic [3:0]        cnt;

  wire ctrl_wr   = host_we && host_addr == CTRL_ADDR;
  wire abort_req = ctrl_wr && host_wdata[1];
  wire start_req = ctrl_wr && host_wdata[0] && !host_wdata[1] && !busy;

  wire [STEP_W-1:0] step    = ram[ptr];
  wire [7:0]        s_addr  = step[7:0];
  wire [DW-1:0]     s_data  = step[DL +: DW];
  wire [WW-1:0]     s_width = step[WL +: WW];
  wire [PW-1:0]     s_pos   = step[PL +: PW];
  wire [3:0]        s_delay = step[YL +: 4];
  wire              s_last  = step[EL];
  wire              s_hit   = s_addr < NREG_L;

  wire [DW-1:0] old_val  = s_hit ? regs[s_addr[RIW-1:0]] : '0;
  wire [DW-1:0] mask     = (~({DW{1'b1}} << s_width)) << s_pos;
  wire [DW-1:0] merged   = (old_val & ~mask) | ((s_data << s_pos) & mask);

  wire exec      = busy && !in_wait && !abort_req;
  wire seq_we    = exec && s_hit;
  wire wait_done = busy && in_wait && tick && cnt == 4'd1 && !abort_req;
  wire advance   = (exec && s_delay == 4'd0) || wait_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      in_wait <= 1'b0;
      cnt     <= '0;
      ptr     <= '0;
    end else if (start_req) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      in_wait <= 1'b0;
      ptr     <= host_wdata[8 +: RAM_AW];
    end else if (busy && abort_req) begin
      busy    <= 1'b0;
      in_wait <= 1'b0;
    end else begin
      if (exec && s_delay != 4'd0) begin
        in_wait <= 1'b1;
        cnt     <= s_delay;
      end
      if (in_wait && tick)
        cnt <= cnt - 4'd1;
      if (advance) begin
        in_wait <= 1'b0;
        if (s_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ptr <= ptr + RAM_AW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (seq_we) begin
      regs[s_addr[RIW-1:0]] <= merged;
    end else if (host_we && !busy && host_addr < NREG_L) begin
      regs[host_addr[RIW-1:0]] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ram_we && !busy)
      ram[ram_addr] <= ram_wdata;
  end

  always_comb begin
    host_rdata = '0;
    if (host_raddr == CTRL_ADDR)
      host_rdata = {{(DW-2){1'b0}}, done, busy};
    else if (host_raddr < NREG_L)
      host_rdata = regs[host_raddr[RIW-1:0]];
  end
endmodule

// File: rtl/reg_write_sequencer_chk.sv
module reg_write_sequencer_chk #(
  parameter int RAM_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic              start_bit,
  input logic              abort_bit,
  input logic              tick,
  input logic              busy,
  input logic              done,
  input logic              in_wait,
  input logic [RAM_AW-1:0] ptr
);
  wire abort_now = ctrl_wr && abort_bit;

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ctrl_wr && start_bit && !abort_bit |=> busy && !done);

  p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort_now |=> !busy && !done);

  p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy));

  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_wait && !tick && !abort_now |=> busy && in_wait && $stable(ptr));

  p_ptr_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !in_wait && !abort_now |=> !busy || in_wait || ptr == $past(ptr) + RAM_AW'(1));
endmodule

bind reg_write_sequencer reg_write_sequencer_chk #(.RAM_AW(RAM_AW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ctrl_wr(host_we && host_addr == CTRL_ADDR),
  .start_bit(host_wdata[0]),
  .abort_bit(host_wdata[1]),
  .tick(tick),
  .busy(busy),
  .done(done),
  .in_wait(in_wait),
  .ptr(ptr)
);

// File: tb/reg_write_sequencer_bench.sv
module reg_write_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEP_W = 38;
  localparam logic [7:0] CTRL = 8'hFF;

  // {old[63:48], data[47:32], width[31:24], pos[23:16], expected[15:0]}
  localparam logic [63:0] VEC [9] = '{
    64'hFFFF_0000_04_04_FF0F,
    64'h0000_000A_04_08_0A00,
    64'h1234_FFFF_03_00_1237,
    64'hAAAA_0000_01_0F_2AAA,
    64'h5555_BEEF_10_00_BEEF,
    64'h0F0F_0003_02_0E_CF0F,
    64'hFFFF_0000_00_05_FFFF,
    64'h0000_00FF_08_0C_F000,
    64'h00FF_0001_14_04_001F
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_we = 1'b0;
  logic [7:0]        host_addr = '0;
  logic [15:0]       host_wdata = '0;
  logic [7:0]        host_raddr = '0;
  logic [15:0]       host_rdata;
  logic              ram_we = 1'b0;
  logic [3:0]        ram_addr = '0;
  logic [STEP_W-1:0] ram_wdata = '0;
  logic              tick = 1'b0;
  logic              busy;
  logic              done;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_write_sequencer u_reg_write_sequencer (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .tick(tick), .busy(busy), .done(done)
  );

  function automatic logic [STEP_W-1:0] mkstep(input logic [7:0] a, input logic [15:0] d,
      input logic [4:0] w, input logic [3:0] p, input logic [3:0] dl, input logic l);
    return {l, dl, p, w, d, a};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic load_step(input logic [3:0] idx, input logic [STEP_W-1:0] w);
    @(negedge clk);
    ram_we = 1'b1; ram_addr = idx; ram_wdata = w;
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    host_raddr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(CTRL, v);  check("R1 status after reset", v, 16'h0000);
    rd(8'd3, v);  check("R1 reg3 after reset", v, 16'h0000);
    rd(8'd15, v); check("R1 reg15 after reset", v, 16'h0000);

    host_write(8'd7, 16'h1234);
    rd(8'd7, v);  check("R2 idle host write", v, 16'h1234);

    for (int i = 0; i < 9; i++) begin
      host_write(8'd3, VEC[i][63:48]);
      load_step(4'd0, mkstep(8'd3, VEC[i][47:32], VEC[i][28:24], VEC[i][19:16], 4'd0, 1'b1));
      host_write(CTRL, 16'h0001);
      wait_idle();
      rd(8'd3, v);
      check($sformatf("R4 merge vector %0d", i), v, VEC[i][15:0]);
    end

    load_step(4'd5, mkstep(8'd1, 16'h1111, 5'd16, 4'd0, 4'd0, 1'b0));
    load_step(4'd6, mkstep(8'd2, 16'h2222, 5'd16, 4'd0, 4'd0, 1'b0));
    load_step(4'd7, mkstep(8'd4, 16'h4444, 5'd16, 4'd0, 4'd0, 1'b1));
    load_step(4'd8, mkstep(8'd9, 16'h9999, 5'd16, 4'd0, 4'd0, 1'b1));
    host_write(CTRL, 16'h0501);
    rd(CTRL, v);  check("R3 busy after start", v, 16'h0001);
    @(negedge clk);
    rd(8'd1, v);  check("R3 first step one edge later", v, 16'h1111);
    rd(8'd2, v);  check("R3 second step not yet", v, 16'h0000);
    @(negedge clk);
    rd(8'd2, v);  check("R9 pointer advanced", v, 16'h2222);
    @(negedge clk);
    rd(CTRL, v);  check("R5 done after last step", v, 16'h0002);
    rd(8'd4, v);  check("R5 last step written", v, 16'h4444);
    rd(8'd9, v);  check("R5 no step after last", v, 16'h0000);

    load_step(4'd10, mkstep(8'd5, 16'h00AA, 5'd8, 4'd0, 4'd3, 1'b0));
    load_step(4'd11, mkstep(8'd6, 16'h0055, 5'd16, 4'd0, 4'd0, 1'b1));
    host_write(CTRL, 16'h0A01);
    rd(CTRL, v);  check("R5 new start clears done", v, 16'h0001);
    repeat (20) @(negedge clk);
    rd(8'd5, v);  check("R6 delayed step written", v, 16'h00AA);
    rd(8'd6, v);  check("R6 waits without tick", v, 16'h0000);
    host_write(8'd7, 16'hFFFF);
    host_write(CTRL, 16'h0001);
    load_step(4'd11, mkstep(8'd6, 16'h0777, 5'd16, 4'd0, 4'd0, 1'b1));
    rd(8'd7, v);  check("R7 host write ignored while busy", v, 16'h1234);
    rd(CTRL, v);  check("R7 start ignored while busy", v, 16'h0001);
    pulse_tick();
    pulse_tick();
    rd(8'd6, v);  check("R6 two ticks not enough", v, 16'h0000);
    pulse_tick();
    rd(CTRL, v);  check("R6 still busy after third tick", v, 16'h0001);
    @(negedge clk);
    rd(8'd6, v);  check("R10 step write ignored while busy", v, 16'h0055);
    rd(CTRL, v);  check("R6 done after delay", v, 16'h0002);

    load_step(4'd12, mkstep(8'd8, 16'h00F0, 5'd8, 4'd0, 4'd5, 1'b0));
    load_step(4'd13, mkstep(8'd10, 16'hABCD, 5'd16, 4'd0, 4'd0, 1'b1));
    host_write(CTRL, 16'h0C01);
    @(negedge clk);
    host_write(CTRL, 16'h0002);
    rd(CTRL, v);  check("R8 abort clears busy, no done", v, 16'h0000);
    repeat (6) pulse_tick();
    rd(8'd10, v); check("R8 no step after abort", v, 16'h0000);
    rd(8'd8, v);  check("R8 step before abort kept", v, 16'h00F0);
    host_write(8'd10, 16'h0042);
    rd(8'd10, v); check("R8 host access restored", v, 16'h0042);

    load_step(4'd15, mkstep(8'd11, 16'h000B, 5'd16, 4'd0, 4'd0, 1'b0));
    load_step(4'd0, mkstep(8'd12, 16'h000C, 5'd16, 4'd0, 4'd0, 1'b1));
    host_write(CTRL, 16'h0F01);
    wait_idle();
    rd(8'd11, v); check("R9 step at index 15", v, 16'h000B);
    rd(8'd12, v); check("R9 wrap to index 0", v, 16'h000C);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule